// File: doc/BRIEF.md
# Thermal Printhead Line Controller

This block prints one dot line on a thermal printhead. A print command starts the line. The block then pulls dot data from a ready/valid word stream and serializes it onto a data pin, MSB of each word first. A separate head clock that runs at half the system rate clocks each bit into the head. After the last bit, the block raises a one-cycle latch pulse. It then fires four strobe groups in turn, never two at once, with fixed idle gaps between them. The strobe width comes from a temperature-derived pulse-width input. The block captures that width when the line starts.

A line-period timer outside the block issues one print command per line period. The block ignores any command that arrives while a line is in progress. A polarity input selects whether the strobe pins idle low and pulse high, or the reverse. A one-cycle done pulse marks the cycle in which the last strobe group returns to idle.

Top module: `tph_line_ctrl`

## Requirements
- R1: A print command sampled while idle starts a line: `busy` is high from the next cycle on, and `pulse_width` is captured in that same edge and used for all four strobes of the line.
- R2: Exactly DOTS bits go out per line. Each bit takes two cycles: `head_data` is set with `head_clk` low, then `head_clk` rises with the data held. Words are consumed MSB first. While no word is valid, shifting stalls with `head_clk` low.
- R3: No two strobe groups are active in the same cycle, and no strobe is active while bits are being shifted or latched.
- R4: `head_latch` is high for exactly one cycle: the cycle right after the cycle in which the last `head_clk` rise appeared.
- R5: Strobe group 0 becomes active in the cycle after the latch cycle. Each group stays active for `pulse_width` cycles, and a width of 0 acts as 1.
- R6: The idle gaps are GAP_A, GAP_B and GAP_C cycles (default 2, 5 and 2). They fall between groups 0 and 1, 1 and 2, and 2 and 3, in that order.
- R7: With `stb_active_low` = 0, the active strobe level is 1 and the idle level is 0. With `stb_active_low` = 1, both levels are inverted.
- R8: `line_done` is a one-cycle pulse in the cycle in which strobe group 3 returns to idle. `busy` falls in the following cycle.
- R9: A print command while `busy` is high has no effect: no extra bits, latch or strobes, and no change to the captured pulse width.
- R10: During reset, `head_clk`, `head_latch`, `strobe`, `line_done`, `busy` and `dot_ready` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one dot clock per cycle |
| rst | input | 1 | Synchronous active-high reset |
| print_cmd | input | 1 | Start of line request |
| dot_word | input | WORD_W | Dot data word, MSB printed first |
| dot_valid | input | 1 | `dot_word` is valid |
| dot_ready | output | 1 | Block takes `dot_word` at this edge if valid |
| pulse_width | input | PW_W | Strobe active time in cycles |
| stb_active_low | input | 1 | 1 selects active-low strobes |
| head_clk | output | 1 | Head shift clock |
| head_data | output | 1 | Head serial data |
| head_latch | output | 1 | Head latch pulse |
| strobe | output | 4 | Strobe groups 0 to 3 |
| line_done | output | 1 | End of line pulse |
| busy | output | 1 | Line in progress |

## Verification
The end-of-line pulse and a new print command can land in the same cycle. In that cycle `busy` is still high, so the command must be dropped and not start a second line. The bench raises the command in exactly the done cycle. It then watches for twenty cycles and expects no new head clock edges, with `busy` at 0. A second command in mid-line, together with a changed pulse width, checks that the captured width and the bit count stay as they were.

// File: rtl/tph_pkg.sv
`timescale 1ns/1ps
package tph_pkg;
  localparam int STB_N = 4;

  function automatic logic [STB_N-1:0] grp_onehot(input logic [1:0] g);
    return STB_N'(1) << g;
  endfunction
endpackage

// File: rtl/tph_shift_engine.sv
`timescale 1ns/1ps
module tph_shift_engine #(
  parameter int DOTS   = 1728,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_valid,
  output logic              word_ready,
  output logic              pclk,
  output logic              pdat,
  output logic              last
);
  localparam int DOT_W = (DOTS > 1) ? $clog2(DOTS) : 1;
  localparam int BIT_W = $clog2(WORD_W + 1);

  logic              active;
  logic              phase;
  logic [DOT_W-1:0]  dot_idx;
  logic [BIT_W-1:0]  bits_left;
  logic [WORD_W-1:0] sreg;

  assign word_ready = active && (bits_left == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      phase     <= 1'b0;
      dot_idx   <= '0;
      bits_left <= '0;
      sreg      <= '0;
      pclk      <= 1'b0;
      pdat      <= 1'b0;
      last      <= 1'b0;
    end else begin
      last <= 1'b0;
      if (go) begin
        active    <= 1'b1;
        phase     <= 1'b0;
        dot_idx   <= '0;
        bits_left <= '0;
        pclk      <= 1'b0;
      end else if (active) begin
        if (bits_left == '0) begin
          pclk <= 1'b0;
          if (word_valid) begin
            sreg      <= word_data;
            bits_left <= BIT_W'(WORD_W);
            phase     <= 1'b0;
          end
        end else if (!phase) begin
          pdat  <= sreg[WORD_W-1];
          pclk  <= 1'b0;
          phase <= 1'b1;
        end else begin
          pclk      <= 1'b1;
          sreg      <= sreg << 1;
          bits_left <= bits_left - BIT_W'(1);
          phase     <= 1'b0;
          if (dot_idx == DOT_W'(DOTS - 1)) begin
            active <= 1'b0;
            last   <= 1'b1;
          end else begin
            dot_idx <= dot_idx + DOT_W'(1);
          end
        end
      end else begin
        pclk <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tph_strobe_seq.sv
`timescale 1ns/1ps
module tph_strobe_seq
  import tph_pkg::*;
#(
  parameter int PW_W  = 8,
  parameter int GAP_A = 2,
  parameter int GAP_B = 5,
  parameter int GAP_C = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [PW_W-1:0]  pw,
  input  logic             active_low,
  output logic [STB_N-1:0] stb,
  output logic             done
);
  localparam int GMAX = (GAP_A > GAP_B) ? ((GAP_A > GAP_C) ? GAP_A : GAP_C)
                                        : ((GAP_B > GAP_C) ? GAP_B : GAP_C);
  localparam int GW   = $clog2(GMAX + 1);
  localparam int CW   = (PW_W > GW) ? PW_W : GW;

  function automatic logic [CW-1:0] gap_len(input logic [1:0] g);
    case (g)
      2'd0:    return CW'(GAP_A);
      2'd1:    return CW'(GAP_B);
      default: return CW'(GAP_C);
    endcase
  endfunction

  logic          running;
  logic          in_gap;
  logic          fin;
  logic [1:0]    grp;
  logic [CW-1:0] cnt;
  logic [CW-1:0] pw_eff;

  assign pw_eff = (pw == '0) ? CW'(1) : CW'(pw);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      in_gap  <= 1'b0;
      fin     <= 1'b0;
      grp     <= '0;
      cnt     <= '0;
      stb     <= '0;
      done    <= 1'b0;
    end else begin
      done <= fin;
      fin  <= 1'b0;
      if (running && !in_gap) stb <= grp_onehot(grp) ^ {STB_N{active_low}};
      else                    stb <= {STB_N{active_low}};
      if (go) begin
        running <= 1'b1;
        in_gap  <= 1'b0;
        grp     <= '0;
        cnt     <= pw_eff;
      end else if (running) begin
        if (cnt == CW'(1)) begin
          if (!in_gap) begin
            if (grp == 2'd3) begin
              running <= 1'b0;
              fin     <= 1'b1;
            end else begin
              in_gap <= 1'b1;
              cnt    <= gap_len(grp);
            end
          end else begin
            in_gap <= 1'b0;
            grp    <= grp + 2'd1;
            cnt    <= pw_eff;
          end
        end else begin
          cnt <= cnt - CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/tph_line_ctrl.sv
`timescale 1ns/1ps
module tph_line_ctrl
  import tph_pkg::*;
#(
  parameter int DOTS   = 1728,
  parameter int WORD_W = 8,
  parameter int PW_W   = 8,
  parameter int GAP_A  = 2,
  parameter int GAP_B  = 5,
  parameter int GAP_C  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              print_cmd,
  input  logic [WORD_W-1:0] dot_word,
  input  logic              dot_valid,
  output logic              dot_ready,
  input  logic [PW_W-1:0]   pulse_width,
  input  logic              stb_active_low,
  output logic              head_clk,
  output logic              head_data,
  output logic              head_latch,
  output logic [STB_N-1:0]  strobe,
  output logic              line_done,
  output logic              busy
);
  logic            accept;
  logic            sh_last;
  logic [PW_W-1:0] pw_line;

  assign accept = print_cmd && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      pw_line    <= '0;
      head_latch <= 1'b0;
    end else begin
      head_latch <= sh_last;
      if (accept) begin
        busy    <= 1'b1;
        pw_line <= pulse_width;
      end else if (line_done) begin
        busy <= 1'b0;
      end
    end
  end

  tph_shift_engine #(.DOTS(DOTS), .WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .go(accept),
    .word_data(dot_word), .word_valid(dot_valid), .word_ready(dot_ready),
    .pclk(head_clk), .pdat(head_data), .last(sh_last)
  );

  tph_strobe_seq #(.PW_W(PW_W), .GAP_A(GAP_A), .GAP_B(GAP_B), .GAP_C(GAP_C)) u_stb (
    .clk(clk), .rst(rst), .go(sh_last), .pw(pw_line),
    .active_low(stb_active_low), .stb(strobe), .done(line_done)
  );
endmodule

// File: rtl/tph_line_ctrl_chk.sv
`timescale 1ns/1ps
module tph_line_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       dot_ready,
  input logic       stb_active_low,
  input logic       head_clk,
  input logic       head_latch,
  input logic [3:0] strobe,
  input logic       line_done,
  input logic       busy
);
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $onehot0(strobe ^ {4{$past(stb_active_low)}}));

  a_r3_quiet_shift: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (head_clk || head_latch)) |-> (strobe == {4{$past(stb_active_low)}}));

  a_r4_latch_after_clk: assert property (@(posedge clk) disable iff (rst)
    head_latch |-> ($past(head_clk) && !head_clk));

  a_r4_latch_one_cycle: assert property (@(posedge clk) disable iff (rst)
    head_latch |=> !head_latch);

  a_r2_ready_in_line: assert property (@(posedge clk) disable iff (rst)
    dot_ready |-> busy);

  a_r8_done_while_busy: assert property (@(posedge clk) disable iff (rst)
    line_done |-> busy);

  a_r8_busy_falls: assert property (@(posedge clk) disable iff (rst)
    line_done |=> (!busy && !line_done));
endmodule

bind tph_line_ctrl tph_line_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .dot_ready(dot_ready), .stb_active_low(stb_active_low),
  .head_clk(head_clk), .head_latch(head_latch), .strobe(strobe),
  .line_done(line_done), .busy(busy)
);

// File: tb/tph_line_ctrl_test.sv
`timescale 1ns/1ps
module tph_line_ctrl_test;
  localparam int DOTS = 256;
  localparam int WW   = 8;
  localparam int NW   = DOTS / WW;
  localparam int PW_W = 8;

  logic clk = 1'b0, rst = 1'b1, print_cmd = 1'b0;
  logic [WW-1:0] dot_word = '0;
  logic dot_valid = 1'b0, dot_ready;
  logic [PW_W-1:0] pulse_width = '0;
  logic stb_active_low = 1'b0;
  logic head_clk, head_data, head_latch, line_done, busy;
  logic [3:0] strobe;

  int checks = 0, failures = 0;

  tph_line_ctrl #(.DOTS(DOTS), .WORD_W(WW), .PW_W(PW_W)) uut (
    .clk(clk), .rst(rst), .print_cmd(print_cmd), .dot_word(dot_word),
    .dot_valid(dot_valid), .dot_ready(dot_ready), .pulse_width(pulse_width),
    .stb_active_low(stb_active_low), .head_clk(head_clk), .head_data(head_data),
    .head_latch(head_latch), .strobe(strobe), .line_done(line_done), .busy(busy)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_width(input int pw);
    return (pw == 0) ? 1 : pw;
  endfunction

  function automatic int exp_gap(input int i);
    return (i == 1) ? 5 : 2;
  endfunction

  // stream driver
  logic [WW-1:0] words [NW];
  int  widx = 0;
  bit  hs_pend = 0, drv_en = 0;
  int  vprob = 100;
  always @(negedge clk) begin
    if (hs_pend) widx++;
    if (drv_en && widx < NW) begin
      dot_word  = words[widx];
      dot_valid = (($urandom % 100) < vprob);
    end else dot_valid = 1'b0;
    hs_pend = dot_valid && dot_ready;
  end

  // output monitor
  int cyc = 0, nbits = 0, last_rise = -1, nlat = 0, lat_cyc = -1;
  int ndone = 0, done_cyc = -1, overlap = 0, quiet = 0;
  int first_c[4], last_c[4], on_cnt[4];
  logic [DOTS-1:0] rx_bits;
  logic pclk_prev = 1'b0;
  bit pol_tb = 0;
  always @(negedge clk) begin
    logic [3:0] act;
    cyc++;
    act = strobe ^ {4{pol_tb}};
    if ($countones(act) > 1) overlap++;
    if (act != 0 && (head_clk || head_latch)) quiet++;
    if (head_clk && !pclk_prev) begin
      if (nbits < DOTS) rx_bits[DOTS-1-nbits] = head_data;
      nbits++;
      last_rise = cyc;
    end
    pclk_prev = head_clk;
    if (head_latch) begin
      if (nlat == 0) lat_cyc = cyc;
      nlat++;
    end
    for (int i = 0; i < 4; i++)
      if (act[i]) begin
        if (on_cnt[i] == 0) first_c[i] = cyc;
        last_c[i] = cyc;
        on_cnt[i]++;
      end
    if (line_done) begin
      if (ndone == 0) done_cyc = cyc;
      ndone++;
    end
  end

  task automatic run_line(input int pw, input bit pol, input int vp, input bit inject, input int pat);
    logic [DOTS-1:0] exp_bits;
    int t, nb_after;
    @(negedge clk); #1;
    stb_active_low = pol; pol_tb = pol; pulse_width = PW_W'(pw); vprob = vp;
    for (int i = 0; i < NW; i++)
      words[i] = (pat == 0) ? 8'hA5 : (pat == 1) ? ((i % 2) ? 8'h01 : 8'h80) : WW'($urandom);
    widx = 0; hs_pend = 0; drv_en = 1;
    nbits = 0; nlat = 0; ndone = 0; overlap = 0; quiet = 0; last_rise = -1;
    lat_cyc = -1; done_cyc = -1; rx_bits = '0;
    for (int i = 0; i < 4; i++) begin on_cnt[i] = 0; first_c[i] = -1; last_c[i] = -1; end
    repeat (3) @(negedge clk);
    #1;
    check(strobe == {4{pol}}, "R7 idle level", strobe, {4{pol}});
    print_cmd = 1'b1;
    @(negedge clk); #1;
    print_cmd = 1'b0;
    check(busy == 1'b1, "R1 busy after command", busy, 1);
    if (inject) begin
      repeat (40) @(negedge clk);
      #1; print_cmd = 1'b1; pulse_width = PW_W'(pw + 7);  // R9 mid-line command
      @(negedge clk); #1; print_cmd = 1'b0;
    end
    t = 0;
    while (ndone == 0 && t < 30000) begin @(negedge clk); #1; t++; end
    check(ndone == 1, "R8 done seen", ndone, 1);
    print_cmd = 1'b1;  // same cycle as done: must be ignored (R9)
    @(negedge clk); #1;
    print_cmd = 1'b0;
    check(busy == 1'b0, "R8 busy falls after done", busy, 0);
    nb_after = nbits;
    repeat (20) @(negedge clk);
    #1;
    check(nbits == nb_after && busy == 1'b0, "R9 no restart", nbits, nb_after);
    check(ndone == 1, "R8 single done pulse", ndone, 1);
    for (int i = 0; i < NW; i++) exp_bits[DOTS-1-WW*i -: WW] = words[i];
    check(nbits == DOTS, "R2 bit count", nbits, DOTS);
    check(rx_bits == exp_bits, "R2 data order", int'(rx_bits[31:0]), int'(exp_bits[31:0]));
    check(nlat == 1, "R4 latch width", nlat, 1);
    check(lat_cyc == last_rise + 1, "R4 latch timing", lat_cyc, last_rise + 1);
    check(first_c[0] == lat_cyc + 1, "R5 first strobe start", first_c[0], lat_cyc + 1);
    for (int i = 0; i < 4; i++) begin
      check(on_cnt[i] == exp_width(pw), "R5 strobe width", on_cnt[i], exp_width(pw));
      check(last_c[i] - first_c[i] + 1 == exp_width(pw), "R5 strobe span",
            last_c[i] - first_c[i] + 1, exp_width(pw));
    end
    for (int i = 0; i < 3; i++)
      check(first_c[i+1] - last_c[i] - 1 == exp_gap(i), "R6 strobe gap",
            first_c[i+1] - last_c[i] - 1, exp_gap(i));
    check(overlap == 0, "R3 overlap", overlap, 0);
    check(quiet == 0, "R3 strobe during shift", quiet, 0);
    check(done_cyc == last_c[3] + 1, "R8 done timing", done_cyc, last_c[3] + 1);
    check(strobe == {4{pol}}, "R7 idle after line", strobe, {4{pol}});
    drv_en = 0;
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    check({head_clk, head_latch, strobe, line_done, busy, dot_ready} == '0,
          "R10 reset outputs", {head_clk, head_latch, strobe, line_done, busy, dot_ready}, 0);
    #1 rst = 1'b0;
    run_line(3,   1'b0, 100, 1'b0, 0);
    run_line(0,   1'b1, 100, 1'b0, 1);
    run_line(1,   1'b0, 30,  1'b1, 2);
    run_line(200, 1'b1, 60,  1'b1, 2);
    for (int k = 0; k < 4; k++)
      run_line(int'($urandom % 41), bit'($urandom % 2), 20 + int'($urandom % 81),
               bit'($urandom % 2), 2);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule